// File: doc/BRIEF.md
# Pause and priority-pause frame generator

This block sits on the transmit side of an Ethernet MAC and produces MAC control frames that ask the link partner to stop sending (XOFF, a nonzero pause time) or to start sending again (XON, a pause time of zero). It can build either a plain pause frame, which covers the whole link, or a per-class pause frame that names one of eight traffic classes. The frame leaves as a byte stream with valid, start, end and ready signals. Alongside the bytes, the block gives the frame kind (plain or per-class, XOFF or XON) and the class number, so that downstream logic can merge the frame with client traffic. The CRC is not part of this block.

Each class has its own request tracker. In level mode one input per class holds the stop request. In pulse mode separate stop and go pulses are used. These pulses come either from configuration-register bits or from hardware signals, and one configuration bit selects the source. A per-class countdown sets a minimum distance between repeated XOFF frames. While a stop request stays active, the XOFF frame is sent again each time that countdown runs out. A fixed-priority arbiter picks the lowest-numbered class that has a pending frame.

Configuration inputs are expected to stay static while a frame is being sent. `rst_n` is expected to arrive already released in step with `clk`.

Top module: `fcg_pause_gen`

## Requirements
- R1: Every frame has the following header, sent most significant byte first. Bytes 0–5 are `cfg_dst_mac` and bytes 6–11 are `cfg_src_mac`. Bytes 12–13 are 0x88, 0x08. Bytes 14–15 are 0x00, 0x01 for a plain frame and 0x01, 0x01 for a per-class frame.
- R2: Every frame is exactly 60 bytes long. `tx_sop` marks byte 0 and `tx_eop` marks byte 59. In a plain frame, bytes 16–17 hold the class-0 pause time for XOFF and zero for XON. All later bytes are zero.
- R3: In a per-class frame, byte 16 is 0 and byte 17 has only bit c set, where c is the class served. Bytes 18–33 are eight 16-bit pause-time fields, with class 0 first. Field c holds `cfg_quanta` slice c for XOFF and zero for XON. All other fields and bytes 34–59 are zero.
- R4: A class in level mode (`cfg_two_bit[c]`=0) requests XOFF while `req_lvl[c]` is high. A high-to-low change of `req_lvl[c]` requests exactly one XON frame.
- R5: A class in pulse mode takes a stop pulse or a go pulse. A stop pulse and a go pulse in the same cycle count as a stop. The pulses come from `sig_xoff`/`sig_xon` when `cfg_use_sig`=1 and from `reg_xoff`/`reg_xon` when `cfg_use_sig`=0. Pulses on the source that is not selected have no effect.
- R6: After an XOFF frame for class c is granted, no further XOFF for c is granted for at least `cfg_sep` slice c cycles. While the stop request stays active, the XOFF is granted again once that count has elapsed.
- R7: When classes are pending, the lowest index wins. With `cfg_pfc_en`=0, only class 0 is served. Other classes keep their pending frames until per-class mode is enabled.
- R8: While `tx_valid` is high and `tx_ready` is low, the byte and the markers hold. A byte advances only on a cycle with both signals high.
- R9: While `tx_valid` is high, `tx_is_pfc`, `tx_is_xoff` and `tx_class` describe the frame being sent and stay constant for the whole frame.
- R10: After reset, `tx_valid` is low and no frame is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pfc_en | input | 1 | 1: per-class frames, 0: plain frames (class 0 only) |
| cfg_two_bit | input | NCLS | Per class: 1 pulse mode, 0 level mode |
| cfg_use_sig | input | 1 | Pulse source: 1 hardware signals, 0 register bits |
| cfg_dst_mac | input | 48 | Destination address |
| cfg_src_mac | input | 48 | Source address |
| cfg_quanta | input | NCLS*16 | Per-class pause time, slice c is class c |
| cfg_sep | input | NCLS*SEP_W | Per-class minimum XOFF spacing in cycles |
| req_lvl | input | NCLS | Level-mode stop request |
| sig_xoff | input | NCLS | Stop pulses from hardware |
| sig_xon | input | NCLS | Go pulses from hardware |
| reg_xoff | input | NCLS | Stop pulses from register bits |
| reg_xon | input | NCLS | Go pulses from register bits |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_valid | output | 1 | Byte present |
| tx_sop | output | 1 | First byte of a frame |
| tx_eop | output | 1 | Last byte of a frame |
| tx_data | output | 8 | Frame byte |
| tx_is_pfc | output | 1 | Frame is per-class |
| tx_is_xoff | output | 1 | Frame is XOFF (else XON) |
| tx_class | output | 3 | Class served |

## Verification
The bench builds the block with the default eight classes and a 10-bit spacing counter. This keeps separations of 100 to 1000 cycles within a short run, so repeated XOFF frames and the grant spacing can be seen several times for one class. With all eight classes present, the arbiter is tested with mixed classes: two simultaneous requests, class masking in plain mode, and both pulse sources and level mode on different classes at the same time. A random-ready phase stalls the stream in the middle of frames, which tests the hold behaviour.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

  localparam int FRAME_LEN = 60;
  localparam int IDX_W     = 6;
  localparam int CLS_W     = 3;
  localparam int Q_W       = 16;

  // Byte i of a flow-control frame (without FCS).
  function automatic logic [7:0] fc_byte(input logic [IDX_W-1:0] i,
                                         input logic [47:0] da,
                                         input logic [47:0] sa,
                                         input logic pfc,
                                         input logic [CLS_W-1:0] cls,
                                         input logic [Q_W-1:0] q);
    int k;
    logic [7:0] b;
    k = int'(i);
    b = 8'h00;
    if (k < 6)        b = da[8*(5-k) +: 8];
    else if (k < 12)  b = sa[8*(11-k) +: 8];
    else if (k == 12) b = 8'h88;
    else if (k == 13) b = 8'h08;
    else if (k == 14) b = pfc ? 8'h01 : 8'h00;
    else if (k == 15) b = 8'h01;
    else if (!pfc) begin
      if (k == 16)      b = q[15:8];
      else if (k == 17) b = q[7:0];
    end else begin
      if (k == 17) b = 8'(1) << cls;
      else if (k >= 18 && k < 34 && ((k - 18) / 2) == int'(cls))
        b = ((k - 18) % 2 == 0) ? q[15:8] : q[7:0];
    end
    return b;
  endfunction

endpackage

// File: rtl/fcg_class_req.sv
module fcg_class_req #(
  parameter int SEP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             two_bit,
  input  logic             use_sig,
  input  logic             lvl,
  input  logic             sig_off,
  input  logic             sig_on,
  input  logic             reg_off,
  input  logic             reg_on,
  input  logic [SEP_W-1:0] sep,
  input  logic             take,
  input  logic             take_off,
  output logic             want_off,
  output logic             want_on
);

  logic             act_q, act_d;
  logic             pon_q, pon_d;
  logic             poff_q, poff_d;
  logic [SEP_W-1:0] tim_q, tim_d;
  logic             xo, xn, fall, tim_en;

  always_comb begin
    xo = use_sig ? sig_off : reg_off;
    xn = use_sig ? sig_on  : reg_on;
    if (two_bit) act_d = xo ? 1'b1 : (xn ? 1'b0 : act_q);
    else         act_d = lvl;
    fall = act_q & ~act_d;

    tim_en = (take & take_off) | (tim_q != '0);
    tim_d  = (take & take_off) ? sep : tim_q - 1'b1;

    pon_d = pon_q;
    if (take & ~take_off) pon_d = 1'b0;
    if (act_d)            pon_d = 1'b0;
    if (fall)             pon_d = 1'b1;

    poff_d = act_d & ~(take & take_off) & (poff_q | (tim_q == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pon_q  <= 1'b0;
      poff_q <= 1'b0;
      tim_q  <= '0;
    end else begin
      act_q  <= act_d;
      pon_q  <= pon_d;
      poff_q <= poff_d;
      if (tim_en) tim_q <= tim_d;
    end
  end

  assign want_off = poff_q;
  assign want_on  = pon_q;

  p_pend_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(pon_q && poff_q));

  p_sep_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tim_q != '0 && !poff_q) |=> !poff_q);

  p_fall_xon_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !act_d) |=> want_on);

endmodule

// File: rtl/fcg_arbiter.sv
module fcg_arbiter #(
  parameter int NCLS = 8
) (
  input  logic                     pfc_en,
  input  logic [NCLS-1:0]          want_off,
  input  logic [NCLS-1:0]          want_on,
  output logic                     any,
  output logic [fcg_pkg::CLS_W-1:0] cls,
  output logic                     off
);

  logic [NCLS-1:0] req;

  always_comb begin
    req = want_off | want_on;
    if (!pfc_en) req = req & NCLS'(1);
    any = |req;
    cls = '0;
    off = 1'b0;
    for (int c = NCLS - 1; c >= 0; c--) begin
      if (req[c]) begin
        cls = fcg_pkg::CLS_W'(c);
        off = want_off[c];
      end
    end
  end

endmodule

// File: rtl/fcg_serializer.sv
module fcg_serializer (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [fcg_pkg::CLS_W-1:0]  in_cls,
  input  logic                       in_off,
  input  logic                       in_pfc,
  input  logic [fcg_pkg::Q_W-1:0]    in_q,
  input  logic [47:0]                da,
  input  logic [47:0]                sa,
  input  logic                       ready,
  output logic                       valid,
  output logic                       sop,
  output logic                       eop,
  output logic [7:0]                 data,
  output logic                       is_pfc,
  output logic                       is_xoff,
  output logic [fcg_pkg::CLS_W-1:0]  cls
);
  import fcg_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             adv;
  logic [CLS_W-1:0] cls_q;
  logic             off_q, pfc_q;
  logic [Q_W-1:0]   q_q;

  always_comb begin
    adv    = busy_q & ready;
    busy_d = busy_q;
    idx_d  = idx_q;
    if (adv) begin
      if (idx_q == LAST) busy_d = 1'b0;
      else               idx_d  = idx_q + 1'b1;
    end
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      cls_q  <= '0;
      off_q  <= 1'b0;
      pfc_q  <= 1'b0;
      q_q    <= '0;
    end else begin
      busy_q <= busy_d;
      if (adv | start) idx_q <= idx_d;
      if (start) begin
        cls_q <= in_cls;
        off_q <= in_off;
        pfc_q <= in_pfc;
        q_q   <= in_off ? in_q : '0;
      end
    end
  end

  assign valid   = busy_q;
  assign sop     = busy_q & (idx_q == '0);
  assign eop     = busy_q & (idx_q == LAST);
  assign data    = fc_byte(idx_q, da, sa, pfc_q, cls_q, q_q);
  assign is_pfc  = pfc_q;
  assign is_xoff = off_q;
  assign cls     = cls_q;

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(data) && $stable(sop) && $stable(eop)));

  p_type_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !(eop && ready)) |=> ($stable(is_pfc) && $stable(is_xoff) && $stable(cls)));

  p_eop_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && eop && ready) |=> !valid);

endmodule

// File: rtl/fcg_pause_gen.sv
module fcg_pause_gen #(
  parameter int NCLS  = 8,
  parameter int SEP_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_pfc_en,
  input  logic [NCLS-1:0]       cfg_two_bit,
  input  logic                  cfg_use_sig,
  input  logic [47:0]           cfg_dst_mac,
  input  logic [47:0]           cfg_src_mac,
  input  logic [NCLS*16-1:0]    cfg_quanta,
  input  logic [NCLS*SEP_W-1:0] cfg_sep,
  input  logic [NCLS-1:0]       req_lvl,
  input  logic [NCLS-1:0]       sig_xoff,
  input  logic [NCLS-1:0]       sig_xon,
  input  logic [NCLS-1:0]       reg_xoff,
  input  logic [NCLS-1:0]       reg_xon,
  input  logic                  tx_ready,
  output logic                  tx_valid,
  output logic                  tx_sop,
  output logic                  tx_eop,
  output logic [7:0]            tx_data,
  output logic                  tx_is_pfc,
  output logic                  tx_is_xoff,
  output logic [2:0]            tx_class
);
  import fcg_pkg::*;

  logic [NCLS-1:0]  want_off, want_on, take;
  logic [Q_W-1:0]   qa [NCLS];
  logic             any, gnt_off, start;
  logic [CLS_W-1:0] gnt_cls;

  assign start = any & ~tx_valid;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign qa[c]   = cfg_quanta[c*16 +: 16];
    assign take[c] = start & (gnt_cls == CLS_W'(c));
    fcg_class_req #(.SEP_W(SEP_W)) i_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .two_bit  (cfg_two_bit[c]),
      .use_sig  (cfg_use_sig),
      .lvl      (req_lvl[c]),
      .sig_off  (sig_xoff[c]),
      .sig_on   (sig_xon[c]),
      .reg_off  (reg_xoff[c]),
      .reg_on   (reg_xon[c]),
      .sep      (cfg_sep[c*SEP_W +: SEP_W]),
      .take     (take[c]),
      .take_off (gnt_off),
      .want_off (want_off[c]),
      .want_on  (want_on[c])
    );
  end

  fcg_arbiter #(.NCLS(NCLS)) i_arb (
    .pfc_en   (cfg_pfc_en),
    .want_off (want_off),
    .want_on  (want_on),
    .any      (any),
    .cls      (gnt_cls),
    .off      (gnt_off)
  );

  fcg_serializer i_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .in_cls  (gnt_cls),
    .in_off  (gnt_off),
    .in_pfc  (cfg_pfc_en),
    .in_q    (qa[gnt_cls]),
    .da      (cfg_dst_mac),
    .sa      (cfg_src_mac),
    .ready   (tx_ready),
    .valid   (tx_valid),
    .sop     (tx_sop),
    .eop     (tx_eop),
    .data    (tx_data),
    .is_pfc  (tx_is_pfc),
    .is_xoff (tx_is_xoff),
    .cls     (tx_class)
  );

  p_take_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  p_std_class0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_is_pfc) |-> (tx_class == '0));

  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && cfg_pfc_en) |-> (((want_off | want_on) & ((NCLS'(1) << gnt_cls) - 1'b1)) == '0));

  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && !any) |=> !tx_valid);

endmodule

// File: tb/test_fcg_pause_gen.sv
module test_fcg_pause_gen;
  localparam int N  = 8;
  localparam int SW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic            cfg_pfc_en = 1'b0;
  logic [N-1:0]    cfg_two_bit = '0;
  logic            cfg_use_sig = 1'b0;
  logic [47:0]     cfg_dst_mac = 48'h0180C2000001;
  logic [47:0]     cfg_src_mac = 48'h02A1B2C3D4E5;
  logic [N*16-1:0] cfg_quanta;
  logic [N*SW-1:0] cfg_sep;
  logic [N-1:0]    req_lvl = '0, sig_xoff = '0, sig_xon = '0, reg_xoff = '0, reg_xon = '0;
  logic            tx_ready = 1'b1;
  logic            tx_valid, tx_sop, tx_eop, tx_is_pfc, tx_is_xoff;
  logic [7:0]      tx_data;
  logic [2:0]      tx_class;

  logic [15:0]   qv [N];
  logic [SW-1:0] sv [N];
  always_comb for (int c = 0; c < N; c++) begin
    cfg_quanta[c*16 +: 16] = qv[c];
    cfg_sep[c*SW +: SW]    = sv[c];
  end

  fcg_pause_gen #(.NCLS(N), .SEP_W(SW)) i_fcg_pause_gen (.*);

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit       m_busy, m_off, m_pfc;
  int       m_idx, m_cls;
  bit       m_act[N], m_pon[N], m_poff[N];
  int       m_tim[N];
  bit [7:0] fr[60];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_idx = 0; m_cls = 0; m_off = 0; m_pfc = 0;
      for (int c = 0; c < N; c++) begin m_act[c] = 0; m_pon[c] = 0; m_poff[c] = 0; m_tim[c] = 0; end
    end else begin
      int g; bit st, goff;
      g = -1;
      for (int c = N - 1; c >= 0; c--)
        if ((m_pon[c] || m_poff[c]) && (cfg_pfc_en || c == 0)) g = c;
      st = !m_busy && g >= 0;
      goff = (g >= 0) ? m_poff[g] : 0;
      if (m_busy && tx_ready) begin
        if (m_idx == 59) m_busy = 0; else m_idx++;
      end
      if (st) begin
        bit [15:0] q;
        q = goff ? qv[g] : 16'h0;
        for (int i = 0; i < 60; i++) fr[i] = 8'h00;
        for (int i = 0; i < 6; i++) begin
          fr[i]   = cfg_dst_mac[47-8*i -: 8];
          fr[6+i] = cfg_src_mac[47-8*i -: 8];
        end
        fr[12] = 8'h88; fr[13] = 8'h08; fr[14] = cfg_pfc_en ? 8'h01 : 8'h00; fr[15] = 8'h01;
        if (!cfg_pfc_en) begin fr[16] = q[15:8]; fr[17] = q[7:0]; end
        else begin fr[17] = 8'(1 << g); fr[18+2*g] = q[15:8]; fr[19+2*g] = q[7:0]; end
        m_busy = 1; m_idx = 0; m_cls = g; m_off = goff; m_pfc = cfg_pfc_en;
      end
      for (int c = 0; c < N; c++) begin
        bit xo, xn, na, tk, npo, npn;
        xo = cfg_use_sig ? sig_xoff[c] : reg_xoff[c];
        xn = cfg_use_sig ? sig_xon[c]  : reg_xon[c];
        if (cfg_two_bit[c]) na = xo ? 1 : (xn ? 0 : m_act[c]);
        else                na = req_lvl[c];
        tk  = st && g == c;
        npo = na && !(tk && goff) && (m_poff[c] || m_tim[c] == 0);
        npn = m_pon[c];
        if (tk && !goff) npn = 0;
        if (na) npn = 0;
        if (m_act[c] && !na) npn = 1;
        if (tk && goff) m_tim[c] = int'(sv[c]);
        else if (m_tim[c] > 0) m_tim[c]--;
        m_act[c] = na; m_poff[c] = npo; m_pon[c] = npn;
      end
    end
  end

  // Per-clock comparison, away from the active edge
  always @(negedge clk) if (rst_n) begin
    chk(tx_valid == m_busy, "R6", "valid", tx_valid, m_busy);
    if (m_busy && tx_valid) begin
      chk(tx_data == fr[m_idx], (m_idx < 16) ? "R1" : (m_pfc ? "R3" : "R2"),
          $sformatf("byte %0d", m_idx), tx_data, fr[m_idx]);
      chk(tx_sop == (m_idx == 0), "R2", "sop", tx_sop, m_idx == 0);
      chk(tx_eop == (m_idx == 59), "R2", "eop", tx_eop, m_idx == 59);
      chk(tx_is_pfc == m_pfc && tx_is_xoff == m_off && int'(tx_class) == m_cls, "R9", "type",
          {tx_is_pfc, tx_is_xoff, tx_class}, {m_pfc, m_off, 3'(m_cls)});
    end
  end

  // Frame counters on accepted last byte
  int cnt_off[N], cnt_on[N], first_cls, n_frames;
  always @(posedge clk) if (rst_n && tx_valid && tx_eop && tx_ready) begin
    if (n_frames == 0) first_cls = int'(tx_class);
    n_frames++;
    if (tx_is_xoff) cnt_off[tx_class]++; else cnt_on[tx_class]++;
  end

  logic [7:0] lfsr = 8'h5A;
  bit rnd_rdy = 0;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tx_ready <= rnd_rdy ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  task automatic wait_n(input int n); repeat (n) @(negedge clk); endtask
  task automatic pulse(ref logic [N-1:0] v, input logic [N-1:0] m);
    @(negedge clk); v = m; @(negedge clk); v = '0;
  endtask
  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    int nf;
    for (int c = 0; c < N; c++) begin qv[c] = 16'h1000 + 16'(c * 16'h0111); sv[c] = SW'(1000); cnt_off[c] = 0; cnt_on[c] = 0; end
    sv[0] = SW'(300); sv[4] = SW'(100);
    first_cls = -1; n_frames = 0;
    wait_n(5); rst_n = 1'b1; wait_n(2);
    chk(tx_valid == 1'b0, "R10", "valid after reset", tx_valid, 0);

    // R4 / R2: level mode, plain frames
    @(negedge clk); req_lvl[0] = 1'b1; wait_n(200);
    @(negedge clk); req_lvl[0] = 1'b0; wait_n(150);
    chk(cnt_off[0] == 1, "R4", "plain XOFF count", cnt_off[0], 1);
    chk(cnt_on[0] == 1, "R4", "plain XON count", cnt_on[0], 1);

    // R7 / R8: per-class, register pulses, random ready
    cfg_pfc_en = 1'b1; cfg_two_bit = 8'hFE; rnd_rdy = 1; n_frames = 0;
    pulse(reg_xoff, 8'b0010_1000); wait_n(400);
    chk(first_cls == 3, "R7", "lowest class first", first_cls, 3);
    chk(cnt_off[3] == 1 && cnt_off[5] == 1, "R7", "both XOFF sent", cnt_off[3] + cnt_off[5], 2);
    pulse(reg_xon, 8'b0010_1000); wait_n(400);
    chk(cnt_on[3] == 1 && cnt_on[5] == 1, "R8", "XON under stalls", cnt_on[3] + cnt_on[5], 2);

    // R5: simultaneous stop and go counts as stop
    @(negedge clk); reg_xoff[1] = 1'b1; reg_xon[1] = 1'b1;
    @(negedge clk); reg_xoff = '0; reg_xon = '0; wait_n(250);
    chk(cnt_off[1] == 1, "R5", "stop wins", cnt_off[1], 1);
    chk(cnt_on[1] == 0, "R5", "no XON on tie", cnt_on[1], 0);
    pulse(reg_xon, 8'b0000_0010); wait_n(250);
    chk(cnt_on[1] == 1, "R5", "go pulse", cnt_on[1], 1);

    // R5: source select, unselected source ignored
    cfg_use_sig = 1'b1; nf = n_frames;
    pulse(reg_xoff, 8'b0100_0000); wait_n(250);
    chk(n_frames == nf, "R5", "register pulse ignored", n_frames, nf);
    pulse(sig_xoff, 8'b0100_0000); wait_n(250);
    chk(cnt_off[6] == 1, "R5", "signal stop", cnt_off[6], 1);
    pulse(sig_xon, 8'b0100_0000); wait_n(250);
    chk(cnt_on[6] == 1, "R5", "signal go", cnt_on[6], 1);

    // R6: repeated XOFF spacing, level mode class 4
    rnd_rdy = 0; wait_n(10); cfg_two_bit = 8'hEE;
    @(negedge clk); req_lvl[4] = 1'b1; wait_n(400);
    @(negedge clk); req_lvl[4] = 1'b0; wait_n(150);
    chk(cnt_off[4] == 4, "R6", "XOFF repeats", cnt_off[4], 4);
    chk(cnt_on[4] == 1, "R4", "single XON", cnt_on[4], 1);

    // R7: plain mode serves only class 0; pending kept
    cfg_pfc_en = 1'b0; cfg_use_sig = 1'b0; nf = n_frames;
    pulse(reg_xoff, 8'b0000_0100); wait_n(200);
    chk(n_frames == nf, "R7", "class 2 masked", n_frames, nf);
    @(negedge clk); cfg_pfc_en = 1'b1; wait_n(200);
    chk(cnt_off[2] == 1, "R7", "class 2 sent when enabled", cnt_off[2], 1);

    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule